// File: doc/BRIEF.md
# Windowed AIS Detector

This block watches a recovered serial bit stream for the Alarm Indication Signal, which is a stream of almost nothing but ones. The stream arrives as a data bit and a strobe that marks the cycles that carry a real bit. Only strobed bits are counted, so the block can run on a system clock faster than the line rate, with gaps between bits.

The block divides the stream into back-to-back windows that do not overlap, and counts the zeros in each window. At the end of each window it judges the count. If the alarm is off and the window held few enough zeros, the alarm is raised. If the alarm is on and the window held enough zeros, the alarm is dropped. The window length and both thresholds depend on a line-mode input, which selects E1 or T1.

The alarm output is registered and moves only at window ends, so once raised it stays up for at least one full window. A one-cycle pulse marks each window end, for observation. A synchronous reset, or any change of the mode input, clears the alarm and starts a new window.

Top module: `ais_window_monitor`

## Requirements
- R1: With `mode_sel` = 0 (E1), a window is 512 strobed bits. `win_end` pulses high for one cycle, in the cycle after the 512th strobed bit of each window.
- R2: With `mode_sel` = 1 (T1), a window is 4632 strobed bits, with the same `win_end` timing as in R1.
- R3: In E1 mode, while `ais` is low, a window with 2 or fewer zeros sets `ais`. A window with 3 or more zeros leaves `ais` low.
- R4: In E1 mode, while `ais` is high, a window with 3 or more zeros clears `ais`. A window with 2 or fewer zeros leaves `ais` high. The zero count includes the window's last bit.
- R5: In T1 mode, while `ais` is low, a window with 4 or fewer zeros sets `ais`. While `ais` is high, a window with 5 or more zeros clears it.
- R6: Except after a restart (R8), `ais` changes only in a cycle where `win_end` is high. The new value appears in the same cycle as the pulse.
- R7: A cycle with `bit_vld` low counts neither a bit nor a zero, whatever the value of `bit_in`.
- R8: Reset, or a change of `mode_sel` from one cycle to the next, clears `ais`, suppresses `win_end`, and starts a new empty window. The bit strobed in that cycle is discarded.
- R9: Any number of zeros above the clear threshold counts as "at or above the threshold", up to a full window of zeros. The count does not wrap.
- R10: `win_end` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Line mode: 0 selects E1, 1 selects T1 |
| bit_vld | input | 1 | High in cycles that carry a received bit |
| bit_in | input | 1 | Received data bit, sampled when `bit_vld` is high |
| ais | output | 1 | Registered alarm flag |
| win_end | output | 1 | One-cycle pulse at each window end |

## Verification
The bench tests each threshold from both sides: 2 and 3 zeros in E1, 4 and 5 zeros in T1. An off-by-one comparison would therefore set or keep the alarm one count wrong.

In one case the only deciding zero is the last bit of the window. A design that judged the window before adding that bit would fail to clear.

Zeros are placed in the gaps between strobed bits, which catches a design that counts unstrobed cycles. Windows of 16 zeros and of all zeros are sent to catch a zero counter that wraps instead of saturating.

The mode is switched and reset is applied partway through a window, with the alarm up. This exposes any leftover bit count, zero count or alarm state, because later window ends would then arrive at the wrong cycle.

// File: rtl/ais_pkg.sv
package ais_pkg;

    typedef enum logic {
        LINE_E1 = 1'b0,
        LINE_T1 = 1'b1
    } line_mode_e;

    // Default window geometry and thresholds per line mode
    localparam int unsigned E1_WIN_BITS    = 512;
    localparam int unsigned T1_WIN_BITS    = 4632;
    localparam int unsigned E1_SET_MAX     = 2;
    localparam int unsigned E1_CLR_MIN     = 3;
    localparam int unsigned T1_SET_MAX     = 4;
    localparam int unsigned T1_CLR_MIN     = 5;
    localparam int unsigned ZERO_SATURATE  = 8;

    // Result of the window that closes in the current cycle
    typedef struct packed {
        logic closing;
        logic may_set;
        logic may_clear;
    } verdict_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ais_window_ctr.sv
module ais_window_ctr
    import ais_pkg::*;
#(
    parameter int unsigned E1_LEN = E1_WIN_BITS,
    parameter int unsigned T1_LEN = T1_WIN_BITS
) (
    input  logic       clk,
    input  logic       restart,
    input  logic       bit_vld,
    input  line_mode_e mode,
    output logic       last_bit
);
    localparam int unsigned MAX_LEN = max_u(E1_LEN, T1_LEN);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN);
    localparam logic [CNT_W-1:0] E1_END = CNT_W'(E1_LEN - 1);
    localparam logic [CNT_W-1:0] T1_END = CNT_W'(T1_LEN - 1);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] end_pos;

    always_comb begin
        end_pos  = (mode == LINE_T1) ? T1_END : E1_END;
        last_bit = bit_vld && (pos_q == end_pos);
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            pos_q <= '0;
        end else if (bit_vld) begin
            pos_q <= last_bit ? '0 : pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/ais_zero_tally.sv
module ais_zero_tally
    import ais_pkg::*;
#(
    parameter int unsigned SAT = ZERO_SATURATE,
    localparam int unsigned ZW = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          restart,
    input  logic          bit_vld,
    input  logic          bit_in,
    input  logic          last_bit,
    output logic [ZW-1:0] zeros_now
);
    localparam logic [ZW-1:0] SAT_V = ZW'(SAT);

    logic [ZW-1:0] tally_q;
    logic [ZW-1:0] bumped;

    always_comb begin
        bumped    = (!bit_in && tally_q != SAT_V) ? tally_q + 1'b1 : tally_q;
        zeros_now = bit_vld ? bumped : tally_q;
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            tally_q <= '0;
        end else if (bit_vld) begin
            tally_q <= last_bit ? '0 : bumped;
        end
    end

endmodule

// File: rtl/ais_judge.sv
module ais_judge
    import ais_pkg::*;
#(
    parameter int unsigned E1_SET = E1_SET_MAX,
    parameter int unsigned E1_CLR = E1_CLR_MIN,
    parameter int unsigned T1_SET = T1_SET_MAX,
    parameter int unsigned T1_CLR = T1_CLR_MIN,
    parameter int unsigned ZW     = 4
) (
    input  logic          clk,
    input  logic          restart,
    input  line_mode_e    mode,
    input  logic          last_bit,
    input  logic [ZW-1:0] zeros_now,
    output logic          ais,
    output logic          win_end
);
    localparam logic [ZW-1:0] E1_SET_V = ZW'(E1_SET);
    localparam logic [ZW-1:0] E1_CLR_V = ZW'(E1_CLR);
    localparam logic [ZW-1:0] T1_SET_V = ZW'(T1_SET);
    localparam logic [ZW-1:0] T1_CLR_V = ZW'(T1_CLR);

    verdict_t v;

    always_comb begin
        v.closing = last_bit;
        if (mode == LINE_T1) begin
            v.may_set   = zeros_now <= T1_SET_V;
            v.may_clear = zeros_now >= T1_CLR_V;
        end else begin
            v.may_set   = zeros_now <= E1_SET_V;
            v.may_clear = zeros_now >= E1_CLR_V;
        end
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            ais     <= 1'b0;
            win_end <= 1'b0;
        end else begin
            win_end <= v.closing;
            if (v.closing) begin
                if (!ais && v.may_set) begin
                    ais <= 1'b1;
                end else if (ais && v.may_clear) begin
                    ais <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/ais_window_monitor.sv
module ais_window_monitor
    import ais_pkg::*;
#(
    parameter int unsigned E1_LEN = E1_WIN_BITS,
    parameter int unsigned T1_LEN = T1_WIN_BITS,
    parameter int unsigned E1_SET = E1_SET_MAX,
    parameter int unsigned E1_CLR = E1_CLR_MIN,
    parameter int unsigned T1_SET = T1_SET_MAX,
    parameter int unsigned T1_CLR = T1_CLR_MIN,
    // must be at least the larger clear threshold
    parameter int unsigned SAT    = ZERO_SATURATE
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_sel,
    input  logic bit_vld,
    input  logic bit_in,
    output logic ais,
    output logic win_end
);
    localparam int unsigned ZW = $clog2(SAT + 1);

    line_mode_e    mode;
    line_mode_e    mode_q;
    logic          restart;
    logic          last_bit;
    logic [ZW-1:0] zeros_now;

    always_comb begin
        mode    = line_mode_e'(mode_sel);
        restart = rst || (mode != mode_q);
    end

    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    ais_window_ctr #(
        .E1_LEN (E1_LEN),
        .T1_LEN (T1_LEN)
    ) u_ctr (
        .clk      (clk),
        .restart  (restart),
        .bit_vld  (bit_vld),
        .mode     (mode),
        .last_bit (last_bit)
    );

    ais_zero_tally #(
        .SAT (SAT)
    ) u_tally (
        .clk       (clk),
        .restart   (restart),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .last_bit  (last_bit),
        .zeros_now (zeros_now)
    );

    ais_judge #(
        .E1_SET (E1_SET),
        .E1_CLR (E1_CLR),
        .T1_SET (T1_SET),
        .T1_CLR (T1_CLR),
        .ZW     (ZW)
    ) u_judge (
        .clk       (clk),
        .restart   (restart),
        .mode      (mode),
        .last_bit  (last_bit),
        .zeros_now (zeros_now),
        .ais       (ais),
        .win_end   (win_end)
    );

endmodule

// File: rtl/ais_window_monitor_chk.sv
module ais_window_monitor_chk (
    input logic clk,
    input logic rst,
    input logic mode_sel,
    input logic bit_vld,
    input logic bit_in,
    input logic ais,
    input logic win_end
);
    logic mode_d;

    always_ff @(posedge clk) begin
        mode_d <= mode_sel;
    end

    // R6: alarm only moves with a boundary pulse when no restart occurs
    a_r6_flag_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == mode_d) |=> (win_end || $stable(ais)));

    // R8: a mode change clears the flag and suppresses the pulse
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != mode_d) |=> (!ais && !win_end));

    // R7: a boundary always follows a strobed bit
    a_r7_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        win_end |-> $past(bit_vld));

    // R10: the boundary pulse lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        win_end |=> !win_end);

    // R3: a rise of the alarm coincides with a boundary
    a_r3_rise_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(ais) |-> win_end);

    // R4: a fall is due to a boundary, a mode change or reset
    a_r4_fall_explained: assert property (@(posedge clk) disable iff (rst)
        $fell(ais) |-> (win_end || $past(mode_sel != mode_d) || $past(rst)));

endmodule

bind ais_window_monitor ais_window_monitor_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .ais      (ais),
    .win_end  (win_end)
);

// File: tb/sim_ais_window_monitor.sv
`timescale 1ns/1ps
module sim_ais_window_monitor;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b1;
    logic ais;
    logic win_end;

    int checks = 0;
    int fails = 0;
    string tag = "R8";
    bit live = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ais_window_monitor u0 (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .ais      (ais),
        .win_end  (win_end)
    );

    // Behavioural reference model
    int   m_cnt = 0;
    int   m_zc = 0;
    bit   m_ais = 0;
    bit   m_win = 0;
    logic m_prev = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_zc = 0; m_ais = 0; m_win = 0;
        end else if (mode_sel !== m_prev) begin
            m_cnt = 0; m_zc = 0; m_ais = 0; m_win = 0;
        end else begin
            m_win = 0;
            if (bit_vld) begin
                m_cnt++;
                if (!bit_in) m_zc++;
                if (m_cnt == (mode_sel ? 4632 : 512)) begin
                    if (!m_ais && m_zc <= (mode_sel ? 4 : 2)) m_ais = 1;
                    else if (m_ais && m_zc >= (mode_sel ? 5 : 3)) m_ais = 0;
                    m_cnt = 0; m_zc = 0; m_win = 1;
                end
            end
        end
        m_prev = mode_sel;
    end

    task automatic chk(input bit ok, input string t, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !done) begin
            chk(ais === m_ais, tag, "ais vs model", int'(ais), int'(m_ais));
            chk(win_end === m_win, tag, "win_end vs model", int'(win_end), int'(m_win));
        end
    end

    task automatic push_bit(input bit b, input int idle);
        repeat (idle) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = 1'b0;   // R7: garbage zero in a gap
        end
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
    endtask

    // Sends one window; on return win_end is visible at this negedge
    task automatic run_window(input int len, input int nz, input bit at_end);
        for (int i = 0; i < len; i++) begin
            bit b;
            if (at_end) b = (i < len - nz) ? 1'b1 : 1'b0;
            else        b = (i < nz) ? 1'b0 : 1'b1;
            push_bit(b, (i % 4 == 3) ? 1 : 0);
        end
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b1;
    endtask

    task automatic at_boundary(input bit exp_ais, input string t);
        chk(win_end === 1'b1, t, "boundary pulse", int'(win_end), 1);
        chk(ais === exp_ais, t, "flag at boundary", int'(ais), int'(exp_ais));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        live = 1'b1;
        chk(ais === 1'b0 && win_end === 1'b0, "R8", "reset state",
            int'({ais, win_end}), 0);
        rst = 1'b0;

        tag = "R1";
        run_window(512, 0, 0);  at_boundary(1'b1, "R3");
        tag = "R4";
        run_window(512, 2, 0);  at_boundary(1'b1, "R4");
        run_window(512, 3, 1);  at_boundary(1'b0, "R4");
        tag = "R3";
        run_window(512, 3, 0);  at_boundary(1'b0, "R3");
        run_window(512, 2, 1);  at_boundary(1'b1, "R3");
        tag = "R9";
        run_window(512, 16, 0); at_boundary(1'b0, "R9");
        run_window(512, 0, 0);  at_boundary(1'b1, "R9");
        run_window(512, 512, 0); at_boundary(1'b0, "R9");
        run_window(512, 1, 0);  at_boundary(1'b1, "R1");

        // R8: mode change partway through a window
        tag = "R8";
        for (int i = 0; i < 200; i++) push_bit(1'b1, 0);
        @(negedge clk);
        mode_sel = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        chk(ais === 1'b0, "R8", "flag after mode change", int'(ais), 0);

        tag = "R2";
        run_window(4632, 0, 0); at_boundary(1'b1, "R5");
        tag = "R5";
        run_window(4632, 4, 1); at_boundary(1'b1, "R5");
        run_window(4632, 5, 0); at_boundary(1'b0, "R5");
        run_window(4632, 4, 0); at_boundary(1'b1, "R2");

        // R8: back to E1 mid-window, then reset mid-window
        tag = "R8";
        for (int i = 0; i < 300; i++) push_bit(1'b1, 1);
        @(negedge clk);
        mode_sel = 1'b0; bit_vld = 1'b0;
        @(negedge clk);
        chk(ais === 1'b0, "R8", "flag after mode return", int'(ais), 0);
        run_window(512, 0, 0);  at_boundary(1'b1, "R1");
        for (int i = 0; i < 100; i++) push_bit(1'b0, 0);
        @(negedge clk);
        rst = 1'b1; bit_vld = 1'b0;
        @(negedge clk);
        chk(ais === 1'b0 && win_end === 1'b0, "R8", "reset mid-window",
            int'({ais, win_end}), 0);
        rst = 1'b0;
        tag = "R7";
        run_window(512, 2, 0);  at_boundary(1'b1, "R7");
        repeat (20) @(negedge clk);
        chk(ais === 1'b1, "R6", "flag held between windows", int'(ais), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule